// File: doc/BRIEF.md
# Inner/Outer Bank Address Combiner

This block turns CPU and PPU bus addresses into physical PRG-ROM and CHR memory byte addresses for a multicart-style banking controller. Switchable inner banks come from bank registers held elsewhere. They are merged with outer PRG and CHR base values using complementary masks. The mask widths depend on size selections made at run time. The PRG side offers three switchable modes with different outer sizes, plus two fixed modes in which only the base is used: a 16 KiB mirrored window and a 32 KiB window.

The CHR side has three paths. The banked path uses 1 KiB inner banks. The plain path uses only the CHR base, which selects one 8 KiB page. The latched path uses a small internal latch written by CPU stores to the mapper's upper address ranges. For every access the block also decides whether CHR goes to RAM or ROM. Register decoding sits outside this block. Its inputs are already-decoded fields.

Top module: `bank_combiner`

## Requirements
- R1: After reset the CHR latch holds zero. In latched CHR mode with size bit 0, the 8 KiB CHR page therefore equals `chr_base & ~3`.
- R2: For `prg_mode` 0, 1 and 2, the inner bank mask is 0x3F, 0x1F and 0x0F respectively. The inner bank is `prg_bank[cpu_addr[14:13]]`, where window 0 is $8000. The 8 KiB page is `(inner & mask) | ((prg_base<<1) & ~mask)`, and `prg_addr[12:0]` equals `cpu_addr[12:0]`.
- R3: For `prg_mode` 3, `prg_addr` is `{prg_base, cpu_addr[13:0]}`, so the same 16 KiB appears in both halves of $8000-$FFFF.
- R4: For `prg_mode` 4 to 7, `prg_addr` is `{prg_base[9:1], cpu_addr[14:0]}`.
- R5: Banked CHR is selected by `chr_fixed`=0. The 1 KiB page is `(inner & m) | ((chr_base<<3) & ~m)`, where inner is `chr_bank[ppu_addr[12:10]]`. m is 0xFF when `chr_size_sel`=0. When `chr_size_sel`=1, m follows the PRG outer size: 0x1FF for mode 0, 0xFF for mode 1, and 0x7F for any other mode.
- R6: Plain CHR is selected by `chr_fixed`=1 and `chr_latched`=0. It gives `chr_addr = {chr_base, ppu_addr[12:0]}`.
- R7: Latched CHR is selected by `chr_fixed`=1 and `chr_latched`=1. The 8 KiB page is `(latch & m) | (chr_base & ~m)`, where m is 3 when `chr_size_sel`=0 and 1 when it is 1.
- R8: The 2-bit latch loads `latch_data` on a clock edge only when `cpu_wr`=1, latched mode is active and `cpu_addr` lies in $8000-$9FFF or $C000-$FFFF. Writes to $A000-$BFFF, or writes made outside latched mode, leave it unchanged.
- R9: `latch_clr` zeroes the latch at the next edge and takes priority over a simultaneous write.
- R10: `chr_ram_sel` is 1 whenever `chr_all_ram`=1. Otherwise it is 1 only when `chr_mixed`=1 and the final CHR address lies in the first 8 KiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| latch_data | input | 2 | CPU data bits for the CHR latch |
| ppu_addr | input | 13 | PPU pattern-space address |
| prg_bank | input | 32 | Four 8-bit inner PRG banks, window 0 in bits 7:0 |
| chr_bank | input | 64 | Eight 8-bit inner 1 KiB CHR banks |
| prg_mode | input | 3 | PRG banking mode |
| prg_base | input | 10 | Outer PRG base, 16 KiB units |
| chr_base | input | 8 | Outer CHR base, 8 KiB units |
| chr_size_sel | input | 1 | Outer CHR size select |
| chr_fixed | input | 1 | 1: plain or latched CHR |
| chr_latched | input | 1 | 1: latched CHR when fixed |
| chr_all_ram | input | 1 | All CHR accesses to RAM |
| chr_mixed | input | 1 | First 8 KiB of CHR to RAM |
| latch_clr | input | 1 | Clear pulse for the CHR latch |
| prg_addr | output | 24 | PRG-ROM byte address |
| chr_addr | output | 21 | CHR byte address |
| chr_ram_sel | output | 1 | 1: CHR access goes to RAM |

## Verification
The assertions check on every cycle the parts of the mapping that can be read from the ports alone:
- the low PRG and CHR address bits pass through unchanged;
- the fixed PRG windows and the plain CHR page use only the base;
- the RAM/ROM selection rules hold;
- the latched page has its low bit cleared in the cycle after a clear.

The masked merges of inner bank and base, the three outer-size choices, and the latch load conditions (address range, mode gating, clear priority) depend on stored state and on the arithmetic of the masks. Only the bench's reference model, run across random and directed scenarios, can show these.

// File: rtl/bc_pkg.sv
// Shared constants for the bank combiner: PRG mode codes and mask widths.
package bc_pkg;
    localparam logic [2:0] PRG_M512 = 3'd0;
    localparam logic [2:0] PRG_M256 = 3'd1;
    localparam logic [2:0] PRG_M128 = 3'd2;
    localparam logic [2:0] PRG_F16  = 3'd3;

    // Bits of an 8 KiB bank number kept from the inner bank for a switchable mode.
    function automatic int unsigned prg_inner_bits(input logic [2:0] mode);
        case (mode)
            PRG_M512: return 6;
            PRG_M256: return 5;
            default:  return 4;
        endcase
    endfunction
endpackage

// File: rtl/prg_map.sv
// PRG address mapper. Merges the windowed inner 8 KiB bank with the 16 KiB
// outer base, or uses the base alone in the fixed 16/32 KiB modes.
// Assumes cpu_addr[14:13] selects the window ($8000 = window 0).
module prg_map import bc_pkg::*; #(
    parameter int PRG_AW = 24,
    parameter int IB_W   = 8
) (
    input  logic [14:0]               cpu_addr,
    input  logic [3:0][IB_W-1:0]      bank_win,
    input  logic [2:0]                mode,
    input  logic [PRG_AW-15:0]        base,
    output logic [PRG_AW-1:0]         addr
);
    localparam int BW = PRG_AW - 13;

    logic [BW-1:0] inner, base8, mask;

    // Builds the inner bank, the base in 8 KiB units and the mode mask.
    always_comb begin
        inner = BW'(bank_win[cpu_addr[14:13]]);
        base8 = {base, 1'b0};
        mask  = BW'((1 << prg_inner_bits(mode)) - 1);
    end

    // Chooses between the masked merge and the fixed windows.
    always_comb begin
        case (mode)
            PRG_M512, PRG_M256, PRG_M128:
                addr = {(inner & mask) | (base8 & ~mask), cpu_addr[12:0]};
            PRG_F16:
                addr = {base, cpu_addr[13:0]};
            default:
                addr = {base[PRG_AW-15:1], cpu_addr[14:0]};
        endcase
    end
endmodule

// File: rtl/chr_latch.sv
// Small CHR page latch. Loads on CPU writes to $8000-$9FFF or $C000-$FFFF
// while latched mode is active; the clear pulse has priority.
module chr_latch #(
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:13]  cpu_hi,
    input  logic          cpu_wr,
    input  logic          active,
    input  logic          clr,
    input  logic [LW-1:0] din,
    output logic [LW-1:0] q
);
    logic hit;

    // Decodes the two address ranges that load the latch.
    always_comb hit = cpu_hi[15] && (cpu_hi[14:13] != 2'b01);

    // Holds the latch; reset and clear zero it, a qualified write loads it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (cpu_wr && active && hit)
            q <= din;
    end
endmodule

// File: rtl/chr_map.sv
// CHR address mapper with banked, plain and latched paths, plus the CHR
// RAM/ROM select. Assumes ppu_addr[12:10] selects the 1 KiB window.
module chr_map import bc_pkg::*; #(
    parameter int CHR_AW = 21,
    parameter int IB_W   = 8,
    parameter int LW     = 2
) (
    input  logic [12:0]               ppu_addr,
    input  logic [7:0][IB_W-1:0]      bank_win,
    input  logic [2:0]                prg_mode,
    input  logic                      size_sel,
    input  logic                      fixed,
    input  logic                      latched,
    input  logic [CHR_AW-14:0]        base,
    input  logic [LW-1:0]             latch,
    input  logic                      all_ram,
    input  logic                      mixed,
    output logic [CHR_AW-1:0]         addr,
    output logic                      ram_sel
);
    localparam int BW     = CHR_AW - 10;
    localparam int BASE_W = CHR_AW - 13;

    logic [BW-1:0]     inner, base1k, m1k;
    logic [BASE_W-1:0] lat8, m8;

    // Picks the 1 KiB mask for banked mode and the 8 KiB mask for latched mode.
    always_comb begin
        if (!size_sel)
            m1k = BW'(9'h0FF);
        else
            m1k = BW'((1 << (prg_inner_bits(prg_mode) + 3)) - 1);
        m8     = size_sel ? BASE_W'(1) : BASE_W'(3);
        inner  = BW'(bank_win[ppu_addr[12:10]]);
        base1k = {base, 3'b000};
        lat8   = BASE_W'(latch);
    end

    // Chooses one of the three CHR address paths.
    always_comb begin
        if (!fixed)
            addr = {(inner & m1k) | (base1k & ~m1k), ppu_addr[9:0]};
        else if (latched)
            addr = {(lat8 & m8) | (base & ~m8), ppu_addr[12:0]};
        else
            addr = {base, ppu_addr[12:0]};
    end

    // Routes to RAM when forced or when mixed mode hits the first 8 KiB.
    always_comb ram_sel = all_ram || (mixed && (addr[CHR_AW-1:13] == '0));
endmodule

// File: rtl/bank_combiner.sv
// Top of the inner/outer bank address combiner. Wires the PRG mapper, the
// CHR latch and the CHR mapper. Assumes decoded mode fields as inputs.
module bank_combiner #(
    parameter int PRG_AW = 24,
    parameter int CHR_AW = 21,
    parameter int IB_W   = 8,
    parameter int LW     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [15:0]               cpu_addr,
    input  logic                      cpu_wr,
    input  logic [LW-1:0]             latch_data,
    input  logic [12:0]               ppu_addr,
    input  logic [3:0][IB_W-1:0]      prg_bank,
    input  logic [7:0][IB_W-1:0]      chr_bank,
    input  logic [2:0]                prg_mode,
    input  logic [PRG_AW-15:0]        prg_base,
    input  logic [CHR_AW-14:0]        chr_base,
    input  logic                      chr_size_sel,
    input  logic                      chr_fixed,
    input  logic                      chr_latched,
    input  logic                      chr_all_ram,
    input  logic                      chr_mixed,
    input  logic                      latch_clr,
    output logic [PRG_AW-1:0]         prg_addr,
    output logic [CHR_AW-1:0]         chr_addr,
    output logic                      chr_ram_sel
);
    logic [LW-1:0] latch_q;
    logic          latch_mode;

    // Latched CHR mode is the fixed path with the latch selected.
    always_comb latch_mode = chr_fixed && chr_latched;

    prg_map #(.PRG_AW(PRG_AW), .IB_W(IB_W)) u_prg (
        .cpu_addr (cpu_addr[14:0]),
        .bank_win (prg_bank),
        .mode     (prg_mode),
        .base     (prg_base),
        .addr     (prg_addr)
    );

    chr_latch #(.LW(LW)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_hi (cpu_addr[15:13]),
        .cpu_wr (cpu_wr),
        .active (latch_mode),
        .clr    (latch_clr),
        .din    (latch_data),
        .q      (latch_q)
    );

    chr_map #(.CHR_AW(CHR_AW), .IB_W(IB_W), .LW(LW)) u_chr (
        .ppu_addr (ppu_addr),
        .bank_win (chr_bank),
        .prg_mode (prg_mode),
        .size_sel (chr_size_sel),
        .fixed    (chr_fixed),
        .latched  (chr_latched),
        .base     (chr_base),
        .latch    (latch_q),
        .all_ram  (chr_all_ram),
        .mixed    (chr_mixed),
        .addr     (chr_addr),
        .ram_sel  (chr_ram_sel)
    );
endmodule

// File: rtl/bank_combiner_chk.sv
// Port-level checker for bank_combiner, attached by bind.
module bank_combiner_chk #(
    parameter int PRG_AW = 24,
    parameter int CHR_AW = 21
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [15:0]          cpu_addr,
    input logic [12:0]          ppu_addr,
    input logic [2:0]           prg_mode,
    input logic [PRG_AW-15:0]   prg_base,
    input logic [CHR_AW-14:0]   chr_base,
    input logic                 chr_fixed,
    input logic                 chr_latched,
    input logic                 chr_all_ram,
    input logic                 chr_mixed,
    input logic                 latch_clr,
    input logic [PRG_AW-1:0]    prg_addr,
    input logic [CHR_AW-1:0]    chr_addr,
    input logic                 chr_ram_sel
);
    AST_PRG_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[12:0] == cpu_addr[12:0]); // R2
    AST_PRG_MIRROR16: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_mode == 3'd3) |-> (prg_addr[13:0] == cpu_addr[13:0] && prg_addr[PRG_AW-1:14] == prg_base)); // R3
    AST_PRG_FIXED32: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_mode >= 3'd4) |-> (prg_addr[PRG_AW-1:15] == prg_base[PRG_AW-15:1])); // R4
    AST_CHR_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[9:0] == ppu_addr[9:0]); // R5
    AST_CHR_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_fixed && !chr_latched) |-> (chr_addr[CHR_AW-1:13] == chr_base)); // R6
    AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(latch_clr) && chr_fixed && chr_latched) |-> (chr_addr[13] == 1'b0)); // R9
    AST_RAM_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        chr_all_ram |-> chr_ram_sel); // R10
    AST_ROM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!chr_all_ram && !chr_mixed) |-> !chr_ram_sel); // R10
endmodule

bind bank_combiner bank_combiner_chk #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_chk (.*);

// File: tb/bank_combiner_test.sv
`timescale 1ns/1ps
module bank_combiner_test;
    logic clk = 0;
    logic rst_n = 0;
    logic [15:0]     cpu_addr = 0;
    logic            cpu_wr = 0;
    logic [1:0]      latch_data = 0;
    logic [12:0]     ppu_addr = 0;
    logic [3:0][7:0] prg_bank = 0;
    logic [7:0][7:0] chr_bank = 0;
    logic [2:0]      prg_mode = 0;
    logic [9:0]      prg_base = 0;
    logic [7:0]      chr_base = 0;
    logic chr_size_sel = 0, chr_fixed = 0, chr_latched = 0;
    logic chr_all_ram = 0, chr_mixed = 0, latch_clr = 0;
    logic [23:0] prg_addr;
    logic [20:0] chr_addr;
    logic        chr_ram_sel;

    int checks = 0, fails = 0;
    int model_latch = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bank_combiner uut (.*);

    function automatic int exp_prg();
        int m, inner, pg;
        inner = prg_bank[cpu_addr[14:13]];
        if (prg_mode <= 2) begin
            m  = (prg_mode == 0) ? 63 : (prg_mode == 1) ? 31 : 15;
            pg = (inner & m) | ((prg_base * 2) & ~m);
            return pg * 8192 + (cpu_addr % 8192);
        end
        if (prg_mode == 3) return prg_base * 16384 + (cpu_addr % 16384);
        return (prg_base / 2) * 32768 + (cpu_addr % 32768);
    endfunction

    function automatic int exp_chr();
        int m, pg;
        if (!chr_fixed) begin
            if (!chr_size_sel) m = 255;
            else m = (prg_mode == 0) ? 511 : (prg_mode == 1) ? 255 : 127;
            pg = (chr_bank[ppu_addr / 1024] & m) | ((chr_base * 8) & ~m);
            return pg * 1024 + (ppu_addr % 1024);
        end
        if (chr_latched) begin
            m  = chr_size_sel ? 1 : 3;
            pg = (model_latch & m) | (chr_base & ~m);
            return pg * 8192 + ppu_addr;
        end
        return chr_base * 8192 + ppu_addr;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compares at negedge+1, then advances one clock and updates the model latch.
    task automatic step(input string chr_tag);
        int ec;
        string pt, ct;
        #1;
        ec = exp_chr();
        pt = (prg_mode <= 2) ? "R2" : (prg_mode == 3) ? "R3" : "R4";
        ct = chr_tag != "" ? chr_tag : (!chr_fixed ? "R5" : chr_latched ? "R7" : "R6");
        check(pt, int'(prg_addr), exp_prg());
        check(ct, int'(chr_addr), ec);
        check("R10", int'(chr_ram_sel),
              int'(chr_all_ram || (chr_mixed && ec < 8192)));
        @(posedge clk);
        if (latch_clr) model_latch = 0;
        else if (cpu_wr && chr_fixed && chr_latched && cpu_addr >= 16'h8000
                 && !(cpu_addr >= 16'hA000 && cpu_addr < 16'hC000))
            model_latch = latch_data;
        @(negedge clk);
    endtask

    task automatic latch_wr(input logic [15:0] a, input logic [1:0] d, input logic clr);
        cpu_addr = a; latch_data = d; cpu_wr = 1; latch_clr = clr;
        step("R8");
        cpu_wr = 0; latch_clr = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chr_fixed = 1; chr_latched = 1; chr_size_sel = 0; chr_base = 8'hFF;
        ppu_addr = 13'h0123;
        step("R1");
        latch_wr(16'h8000, 2'd3, 0);
        step("R8");
        latch_wr(16'hC000, 2'd1, 1);
        step("R9");
        latch_wr(16'hA000, 2'd2, 0);
        step("R8");
        chr_latched = 0;
        latch_wr(16'hE000, 2'd3, 0);
        chr_latched = 1;
        step("R8");
        latch_wr(16'hFFFF, 2'd1, 0);
        chr_size_sel = 1;
        step("R7");
        for (int i = 0; i < 3000; i++) begin
            cpu_addr = 16'($urandom); ppu_addr = 13'($urandom);
            for (int w = 0; w < 4; w++) prg_bank[w] = 8'($urandom);
            for (int w = 0; w < 8; w++) chr_bank[w] = 8'($urandom);
            prg_mode = 3'($urandom); prg_base = 10'($urandom); chr_base = 8'($urandom);
            chr_size_sel = 1'($urandom); chr_fixed = 1'($urandom); chr_latched = 1'($urandom);
            chr_all_ram = ($urandom % 4) == 0; chr_mixed = 1'($urandom);
            cpu_wr = 1'($urandom); latch_data = 2'($urandom);
            latch_clr = ($urandom % 8) == 0;
            if ($urandom % 4 == 0) chr_base[7:2] = 0;
            step("");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule